// File: doc/BRIEF.md
# Universal registered bus transceiver

This block moves data between two ports, A and B, in both directions at once. Each direction has its own storage element with three behaviours: it passes the input straight through, it keeps the last value, or it takes the input on the rising edge of a strobe. Each direction also has its own output enable, and the two enables have opposite polarities. The block is fully synchronous to one system clock. Strobes are sampled signals, and their rising edges are found by comparing one sample with the one before.

Instead of tri-state pins, each port has a data input, a data output and a drive flag. The drive flag tells the surrounding logic whether the port owns the wire. When both ports drive in the same cycle, a clash flag is raised so that a bench can look for contention.

Top module: `univ_reg_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both stored words to zero. In the first cycle after reset, both drive flags and the clash flag are 0.
- R2: While `ab_le` is 1, `b_dout` equals `a_din` in the same cycle, bit for bit and not inverted.
- R3: While `ab_le` is 0 and no strobe rising edge is seen, `b_dout` keeps its stored value whatever `a_din` does.
- R4: A rising edge of `ab_strb` is seen at a clock edge where `ab_strb` is sampled 1 and was sampled 0 at the clock edge before. If `ab_le` is 0 at that clock edge, the stored word takes `a_din`, and `b_dout` shows it from that clock edge on.
- R5: A strobe edge while `ab_le` is 1 has no extra effect. After `ab_le` falls, the stored word is `a_din` as sampled at the last clock edge where `ab_le` was 1.
- R6: `b_drv` is active high. After each clock edge it equals the value of `ab_oe` sampled at that edge.
- R7: The B-to-A direction (`ba_le`, `ba_strb`, `b_din` to `a_dout`) follows the rules of R2 to R5 with its own controls.
- R8: `a_drv` is active low on its control. After each clock edge it equals the inverse of the value of `ba_oe_n` sampled at that edge.
- R9: `bus_clash` is 1 exactly in the cycles where `a_drv` and `b_drv` are both 1.
- R10: The two directions are independent. The controls and data of one direction never change the stored word, output data or drive flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_din | input | 18 | Data read from the A wire |
| a_dout | output | 18 | Data offered to the A wire (B-to-A path) |
| a_drv | output | 1 | A wire is driven by this block |
| b_din | input | 18 | Data read from the B wire |
| b_dout | output | 18 | Data offered to the B wire (A-to-B path) |
| b_drv | output | 1 | B wire is driven by this block |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B pass-through select |
| ab_strb | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A pass-through select |
| ba_strb | input | 1 | B-to-A capture strobe |
| bus_clash | output | 1 | Both ports driven in this cycle |

## Verification
Two things can fall in the same cycle: a strobe rising edge and a high latch enable. The bench provokes this by raising the strobe while the element is passing data, then dropping the enable. The stored word must then be the input from the last clock edge with the enable high, and not a value tied to the strobe. The bench also turns on both output enables together, and changes one direction's controls while the other direction is capturing. A behavioural reference model, updated on every clock, judges the data, drive and clash outputs in each case.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   localparam int XCVR_W = 18;

   typedef enum logic [1:0] {
      MODE_HOLD = 2'd0,
      MODE_PASS = 2'd1,
      MODE_CAPT = 2'd2
   } lane_mode_e;

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic strb_i,
   output logic rise_o
);

   logic strb_q;

   // previous sample keeps tracking through reset so no false edge appears
   always_ff @(posedge clk) begin
      strb_q <= strb_i;
   end

   assign rise_o = strb_i & ~strb_q;

   // R4
   rise_needs_low_prev_chk: assert property (@(posedge clk) disable iff (rst)
      rise_o |-> !$past(strb_i));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W           = XCVR_W,
   parameter bit OE_ACT_HIGH = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         le_i,
   input  logic         strb_i,
   input  logic         oe_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o,
   output logic         drv_o
);

   generate
      if (W < 1) begin : g_bad_width
         $error("xcvr_lane: W must be at least 1");
      end
   endgenerate

   logic       rise;
   lane_mode_e mode;
   logic [W-1:0] held_q;
   logic       oe_on;
   logic       drv_q;

   xcvr_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .strb_i (strb_i),
      .rise_o (rise)
   );

   always_comb begin
      if (le_i)      mode = MODE_PASS;
      else if (rise) mode = MODE_CAPT;
      else           mode = MODE_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst)                    held_q <= '0;
      else if (mode != MODE_HOLD) held_q <= din_i;
   end

   assign dout_o = (mode == MODE_PASS) ? din_i : held_q;

   generate
      if (OE_ACT_HIGH) begin : g_oe_high
         assign oe_on = oe_i;
      end else begin : g_oe_low
         assign oe_on = ~oe_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) drv_q <= 1'b0;
      else     drv_q <= oe_on;
   end

   assign drv_o = drv_q;

   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!le_i && !rise) |=> $stable(held_q));
   // R4
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!le_i && rise) |=> (held_q == $past(din_i)));
   // R5
   pass_track_chk: assert property (@(posedge clk) disable iff (rst)
      le_i |=> (held_q == $past(din_i)));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (held_q == '0 && !drv_q));

endmodule

// File: rtl/univ_reg_xcvr.sv
module univ_reg_xcvr
   import xcvr_pkg::*;
#(
   parameter int W = XCVR_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_din,
   output logic [W-1:0] a_dout,
   output logic         a_drv,
   input  logic [W-1:0] b_din,
   output logic [W-1:0] b_dout,
   output logic         b_drv,
   input  logic         ab_oe,
   input  logic         ab_le,
   input  logic         ab_strb,
   input  logic         ba_oe_n,
   input  logic         ba_le,
   input  logic         ba_strb,
   output logic         bus_clash
);

   xcvr_lane #(.W(W), .OE_ACT_HIGH(1'b1)) u_ab (
      .clk    (clk),
      .rst    (rst),
      .le_i   (ab_le),
      .strb_i (ab_strb),
      .oe_i   (ab_oe),
      .din_i  (a_din),
      .dout_o (b_dout),
      .drv_o  (b_drv)
   );

   xcvr_lane #(.W(W), .OE_ACT_HIGH(1'b0)) u_ba (
      .clk    (clk),
      .rst    (rst),
      .le_i   (ba_le),
      .strb_i (ba_strb),
      .oe_i   (ba_oe_n),
      .din_i  (b_din),
      .dout_o (a_dout),
      .drv_o  (a_drv)
   );

   assign bus_clash = a_drv & b_drv;

   // R6
   b_drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
      ab_oe |=> b_drv);
   // R8
   a_drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
      ba_oe_n |=> !a_drv);
   // R9
   no_clash_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!ab_oe || ba_oe_n) |=> !bus_clash);

endmodule

// File: tb/univ_reg_xcvr_tb.sv
module univ_reg_xcvr_tb;

   localparam int XW     = 18;
   localparam int PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [XW-1:0] a_din = '0, b_din = '0;
   logic [XW-1:0] a_dout, b_dout;
   logic          a_drv, b_drv, bus_clash;
   logic          ab_oe = 1'b0, ab_le = 1'b0, ab_strb = 1'b0;
   logic          ba_oe_n = 1'b1, ba_le = 1'b0, ba_strb = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model state
   logic [XW-1:0] m_ab_hold = '0, m_ba_hold = '0;
   logic          m_ab_prev = 1'b0, m_ba_prev = 1'b0;
   logic          m_a_drv = 1'b0, m_b_drv = 1'b0;
   int            since_rst = 0;

   always #(PERIOD/2) clk = ~clk;

   univ_reg_xcvr #(.W(XW)) u_dut (
      .clk(clk), .rst(rst),
      .a_din(a_din), .a_dout(a_dout), .a_drv(a_drv),
      .b_din(b_din), .b_dout(b_dout), .b_drv(b_drv),
      .ab_oe(ab_oe), .ab_le(ab_le), .ab_strb(ab_strb),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strb(ba_strb),
      .bus_clash(bus_clash)
   );

   task automatic chk(input string tag, input logic [XW-1:0] act, input logic [XW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare outputs against the model, then advance one clock
   task automatic step();
      logic [XW-1:0] eb, ea;
      #1;
      if (!rst) begin
         eb = ab_le ? a_din : m_ab_hold;
         ea = ba_le ? b_din : m_ba_hold;
         chk(since_rst == 0 ? "R1 b_dout" : (ab_le ? "R2 b_dout" : "R3 b_dout"), b_dout, eb);
         chk(since_rst == 0 ? "R1 a_dout" : (ba_le ? "R7 a_dout" : "R7 hold a_dout"), a_dout, ea);
         chk(since_rst == 0 ? "R1 b_drv" : "R6 b_drv", XW'(b_drv), XW'(m_b_drv));
         chk(since_rst == 0 ? "R1 a_drv" : "R8 a_drv", XW'(a_drv), XW'(m_a_drv));
         chk("R9 bus_clash", XW'(bus_clash), XW'(m_a_drv & m_b_drv));
      end
      @(posedge clk);
      if (rst) begin
         m_ab_hold = '0; m_ba_hold = '0;
         m_a_drv = 1'b0; m_b_drv = 1'b0;
         since_rst = 0;
      end else begin
         if (ab_le || (ab_strb && !m_ab_prev)) m_ab_hold = a_din;
         if (ba_le || (ba_strb && !m_ba_prev)) m_ba_hold = b_din;
         m_b_drv = ab_oe;
         m_a_drv = !ba_oe_n;
         since_rst++;
      end
      m_ab_prev = ab_strb;
      m_ba_prev = ba_strb;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      step(); step();
      rst = 1'b0;
      // R1: first cycle after reset
      a_din = 18'h3ffff; b_din = 18'h2aaaa;
      step();
      // R2: pass-through, several patterns
      ab_le = 1'b1;
      a_din = 18'h15555; step();
      a_din = 18'h00001; step();
      a_din = 18'h20000; step();
      // R5: strobe edge while passing, then drop enable
      ab_strb = 1'b1; a_din = 18'h1234a; step();
      ab_le = 1'b0; a_din = 18'h0beef; step();
      // R3: hold with steady strobe while input changes
      a_din = 18'h3c3c3; step();
      ab_strb = 1'b0; a_din = 18'h01010; step();
      // R4: capture on rising edge
      ab_strb = 1'b1; a_din = 18'h2f00d; step();
      a_din = 18'h00000; step();
      // R6 and R8: enables; R9: both on
      ab_oe = 1'b1; step(); step();
      ba_oe_n = 1'b0; step(); step();
      ab_oe = 1'b0; step(); step();
      ba_oe_n = 1'b1; step();
      // R7 and R10: B-to-A captures while A-to-B is toggled
      ba_le = 1'b1; b_din = 18'h1aaaa; ab_strb = 1'b0; step();
      ba_le = 1'b0; b_din = 18'h05555; ab_strb = 1'b1; a_din = 18'h0f0f0; step();
      ba_strb = 1'b1; b_din = 18'h3e3e3; step();
      b_din = 18'h11111; step();
      // R1: reset mid-run clears state
      rst = 1'b1; step();
      rst = 1'b0; ab_le = 1'b0; ba_le = 1'b0; step();
      // R10: mixed random traffic on both directions
      for (int i = 0; i < 400; i++) begin
         a_din   = XW'($urandom);
         b_din   = XW'($urandom);
         ab_le   = ($urandom % 4) == 0;
         ba_le   = ($urandom % 4) == 0;
         ab_strb = $urandom % 2;
         ba_strb = $urandom % 2;
         ab_oe   = $urandom % 2;
         ba_oe_n = $urandom % 2;
         step();
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule